// File: doc/BRIEF.md
# Two-Bank DRAM Controller with CAS-before-RAS Refresh

This block drives asynchronous DRAM in two independently controlled banks, one per address area. A single request stream (valid/ready) carries a bank select, a word address, a write flag, byte-lane enables and write data. The controller splits the address into row and column according to each bank's column-width setting. It then sequences the row strobe, the column strobes, the write strobes and the multiplexed address pins. Each access ends with a one-cycle completion pulse that carries the read data.

Each bank can keep its row open after an access (page mode). A later request to that same open row skips the row phase. A request to another row of an open bank first precharges that bank. A programmable interval timer raises refresh requests. Refresh takes priority over new requests: every open page is closed, then a CAS-before-RAS cycle runs on both banks. A level-sensitive self-refresh request closes the pages and holds both strobe groups low until the request is withdrawn.

The request stream is back-pressured only by `req_ready`. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a request waits, the requester must hold its fields stable. The completion pulse `rsp_valid` cannot be stalled.

Top module: `dramc_two_bank`

## Requirements
- R1: Each bank has its own row strobe and its own open-row record. An access to one bank leaves the other bank's open page, and its row strobe (low), untouched.
- R2: With page mode off in that bank and no wait, `rsp_valid` is high in the 4th cycle after acceptance. `req_ready` returns in the 6th cycle, so an access takes 5 cycles. The row strobe is low from cycle 1 to cycle 4. In cycle 5 (precharge) all strobes are high. After reset all strobes are high (active low), `req_ready` is 1 and `rsp_valid` is 0.
- R3: With page mode on, a request to the open row of that bank is a hit. Its `rsp_valid` comes in cycle 2, and `req_ready` returns in cycle 3.
- R4: With page mode on, a request to a different row of an open bank adds one precharge cycle. `rsp_valid` then comes in cycle 5.
- R5: When a bank's wait bit is set, one extra cycle is added to the row phase and one to the column phase. A closed-page access then answers in cycle 6.
- R6: Column width per bank is set by a 2-bit code: 0→8, 1→9, 2→10, 3→12 bits. The column is the low address bits and the row is the next 12 bits. The row appears on `dram_addr` in the first row-phase cycle. The column appears in the column phase.
- R7: In dual-CAS mode (`cfg_dual_we[b]`=0), `dram_cas_n[i]` is low for each enabled lane i, and both `dram_we_n` bits are low on a write. In dual-WE mode, both CAS bits are low and `dram_we_n[i]` is low for each enabled lane on a write. All WE bits are high on a read.
- R8: With a nonzero interval N, a refresh request is raised every N×PRESCALE cycles. An interval of 0 raises none.
- R9: A pending refresh blocks request acceptance. Before the refresh starts, any open page is closed with one cycle in which all strobes are high. The refresh then drives both CAS low with both RAS high, and lowers RAS in the next cycle.
- R10: While self-refresh is requested, pages are closed and then CAS and RAS go low in that order and stay low. No request is accepted. On release, RAS rises one cycle before CAS.
- R11: A request is taken only when `req_ready` is high. A request held while the controller is busy is neither lost nor answered before it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_bank | input | 1 | Target bank |
| req_addr | input | 24 | Word address within the bank |
| req_we | input | 1 | 1 = write |
| req_be | input | 2 | Byte-lane enables |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 16 | Read data |
| cfg_colw | input | 4 | Column-width code, 2 bits per bank |
| cfg_dual_we | input | 2 | Strobe arrangement per bank |
| cfg_wait | input | 2 | Extra-wait enable per bank |
| cfg_page | input | 2 | Page-mode enable per bank |
| cfg_ref_interval | input | 6 | Refresh interval in prescaled ticks, 0 = off |
| selfref_req | input | 1 | Self-refresh request (level) |
| dram_ras_n | output | 2 | Row strobe per bank |
| dram_cas_n | output | 2 | Column strobes |
| dram_we_n | output | 2 | Write strobes |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Write data to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 16 | Read data from the DRAM |

## Verification
Accesses are tried with page mode off, with page mode on to a new row, to the same row and to another row, and with waits. These patterns tell the open-page hit, miss and closed cases apart by their latency. Writes with single-lane enables in each strobe arrangement separate the dual-CAS and dual-WE decodes. Using an 8-bit and a 12-bit column width shows whether the row and column split follow the bank's own code. The refresh test starts with pages open, which shows the precharge-then-CBR ordering. It then measures the spacing of refresh starts and checks that an interval of 0 stops them. Finally, a request held during self-refresh shows that nothing is accepted until release.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PRE, S_RAS, S_RASW, S_COL, S_CAS1, S_CASW, S_CAS2, S_PCH,
    S_RPRE, S_RCAS, S_RRAS, S_RHOLD, S_REND,
    S_SPRE, S_SCAS, S_SHOLD, S_SEXIT
  } seq_state_e;

  function automatic int unsigned col_width(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 9;
      2'd2:    return 10;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/dramc_bank.sv
module dramc_bank
  import dramc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        colsel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              row_ld,
  input  logic              open_set,
  input  logic              open_clr,
  output logic [ROW_W-1:0]  req_col,
  output logic [ROW_W-1:0]  row_q,
  output logic              is_open,
  output logic              hit
);
  logic [ROW_W-1:0]  req_row;
  logic [ADDR_W-1:0] col_mask;
  int unsigned       cw;

  always_comb begin
    cw       = col_width(colsel);
    col_mask = (ADDR_W'(1) << cw) - ADDR_W'(1);
    req_col  = ROW_W'(req_addr & col_mask);
    req_row  = ROW_W'(req_addr >> cw);
  end

  assign hit = is_open && (row_q == req_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      is_open <= 1'b0;
    end else begin
      if (row_ld) row_q <= req_row;
      if (open_clr)      is_open <= 1'b0;
      else if (open_set) is_open <= 1'b1;
    end
  end

  AST_OPEN_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_open) |-> $past(open_set)); // R1

endmodule

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
  parameter int PRESCALE = 4,
  parameter int REF_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REF_W-1:0] interval,
  input  logic             ack,
  output logic             pend
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [REF_W-1:0] cnt_q;
  logic             tick, wrap, enabled;

  assign enabled = (interval != '0);
  assign tick    = run && (pre_q == PRE_W'(PRESCALE - 1));
  assign wrap    = ({1'b0, cnt_q} + (REF_W+1)'(1)) >= {1'b0, interval};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (run) pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (!enabled)  cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + REF_W'(1);
      if (enabled && tick && wrap) pend <= 1'b1;
      else if (ack)                pend <= 1'b0;
    end
  end

  AST_NO_PEND_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !$past(pend) && $past(interval) == '0) |-> !pend); // R8

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              ref_pend,
  input  logic              selfref_req,
  input  logic              any_open,
  input  logic              hit_sel,
  input  logic              open_sel,
  input  logic [NBANK-1:0]  cfg_page,
  input  logic [NBANK-1:0]  cfg_wait,
  output seq_state_e        state_q,
  output logic [BANK_W-1:0] cur_bank,
  output logic              req_ready,
  output logic              ref_ack,
  output logic              timer_run,
  output logic [NBANK-1:0]  open_set,
  output logic [NBANK-1:0]  open_clr,
  output logic [NBANK-1:0]  row_ld
);
  seq_state_e        state_d;
  logic              fire, wt;
  logic [BANK_W-1:0] bank_sel;
  logic              clr_one, clr_all, set_one;

  assign req_ready = (state_q == S_IDLE) && !ref_pend && !selfref_req;
  assign fire      = req_valid && req_ready;
  assign bank_sel  = (state_q == S_IDLE) ? req_bank : cur_bank;
  assign wt        = cfg_wait[cur_bank];
  assign ref_ack   = (state_q == S_IDLE) && ref_pend;
  assign timer_run = !(state_q inside {S_SPRE, S_SCAS, S_SHOLD, S_SEXIT});

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: begin
        if (ref_pend)         state_d = any_open ? S_RPRE : S_RCAS;
        else if (selfref_req) state_d = any_open ? S_SPRE : S_SCAS;
        else if (req_valid) begin
          if (!open_sel)                          state_d = S_RAS;
          else if (hit_sel && cfg_page[req_bank]) state_d = S_CAS1;
          else                                    state_d = S_PRE;
        end
      end
      S_PRE:   state_d = S_RAS;
      S_RAS:   state_d = wt ? S_RASW : S_COL;
      S_RASW:  state_d = S_COL;
      S_COL:   state_d = S_CAS1;
      S_CAS1:  state_d = wt ? S_CASW : S_CAS2;
      S_CASW:  state_d = S_CAS2;
      S_CAS2:  state_d = cfg_page[cur_bank] ? S_IDLE : S_PCH;
      S_PCH:   state_d = S_IDLE;
      S_RPRE:  state_d = S_RCAS;
      S_RCAS:  state_d = S_RRAS;
      S_RRAS:  state_d = S_RHOLD;
      S_RHOLD: state_d = S_REND;
      S_REND:  state_d = S_IDLE;
      S_SPRE:  state_d = S_SCAS;
      S_SCAS:  state_d = S_SHOLD;
      S_SHOLD: state_d = selfref_req ? S_SHOLD : S_SEXIT;
      S_SEXIT: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign set_one = (state_d == S_RAS) && (state_q != S_RAS);
  assign clr_one = ((state_q == S_IDLE) && (state_d == S_PRE)) ||
                   ((state_q == S_CAS2) && (state_d == S_PCH));
  assign clr_all = (state_q == S_IDLE) && (state_d inside {S_RPRE, S_SPRE});

  for (genvar g = 0; g < NBANK; g++) begin : g_bank_ctl
    assign open_set[g] = set_one && (bank_sel == BANK_W'(g));
    assign open_clr[g] = clr_all || (clr_one && (bank_sel == BANK_W'(g)));
    assign row_ld[g]   = fire && (req_bank == BANK_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_bank <= '0;
    end else begin
      state_q <= state_d;
      if (fire) cur_bank <= req_bank;
    end
  end

  AST_HIT_SKIPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_IDLE && state_q == S_CAS1) |-> $past(hit_sel)); // R3
  AST_SELF_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {S_SCAS, S_SHOLD}) |-> !fire); // R10

endmodule

// File: rtl/dramc_two_bank.sv
module dramc_two_bank
  import dramc_pkg::*;
#(
  parameter int NBANK    = 2,
  parameter int ADDR_W   = 24,
  parameter int ROW_W    = 12,
  parameter int DATA_W   = 16,
  parameter int REF_W    = 6,
  parameter int PRESCALE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_we,
  input  logic [LANES-1:0]      req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic [2*NBANK-1:0]    cfg_colw,
  input  logic [NBANK-1:0]      cfg_dual_we,
  input  logic [NBANK-1:0]      cfg_wait,
  input  logic [NBANK-1:0]      cfg_page,
  input  logic [REF_W-1:0]      cfg_ref_interval,
  input  logic                  selfref_req,
  output logic [NBANK-1:0]      dram_ras_n,
  output logic [LANES-1:0]      dram_cas_n,
  output logic [LANES-1:0]      dram_we_n,
  output logic [ROW_W-1:0]      dram_addr,
  output logic [DATA_W-1:0]     dram_dq_out,
  output logic                  dram_dq_oe,
  input  logic [DATA_W-1:0]     dram_dq_in
);
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int LANES  = DATA_W / 8;

  seq_state_e        state_q;
  logic [BANK_W-1:0] cur_bank;
  logic              ref_pend, ref_ack, timer_run, fire;
  logic [NBANK-1:0]  open_set, open_clr, row_ld, b_open, b_hit;
  logic [ROW_W-1:0]  b_col [NBANK];
  logic [ROW_W-1:0]  b_row [NBANK];
  logic [ROW_W-1:0]  lat_col;
  logic              lat_we;
  logic [LANES-1:0]  lat_be;
  logic [DATA_W-1:0] lat_wdata;
  logic              in_col, in_cas, in_row, strobe_hold, ras_both;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    dramc_bank #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .colsel   (cfg_colw[2*g +: 2]),
      .req_addr (req_addr),
      .row_ld   (row_ld[g]),
      .open_set (open_set[g]),
      .open_clr (open_clr[g]),
      .req_col  (b_col[g]),
      .row_q    (b_row[g]),
      .is_open  (b_open[g]),
      .hit      (b_hit[g])
    );
  end

  dramc_ref_timer #(.PRESCALE(PRESCALE), .REF_W(REF_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (timer_run),
    .interval (cfg_ref_interval),
    .ack      (ref_ack),
    .pend     (ref_pend)
  );

  dramc_seq #(.NBANK(NBANK), .BANK_W(BANK_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_bank    (req_bank),
    .ref_pend    (ref_pend),
    .selfref_req (selfref_req),
    .any_open    (|b_open),
    .hit_sel     (b_hit[req_bank]),
    .open_sel    (b_open[req_bank]),
    .cfg_page    (cfg_page),
    .cfg_wait    (cfg_wait),
    .state_q     (state_q),
    .cur_bank    (cur_bank),
    .req_ready   (req_ready),
    .ref_ack     (ref_ack),
    .timer_run   (timer_run),
    .open_set    (open_set),
    .open_clr    (open_clr),
    .row_ld      (row_ld)
  );

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_be    <= '0;
      lat_wdata <= '0;
    end else if (fire) begin
      lat_col   <= b_col[req_bank];
      lat_we    <= req_we;
      lat_be    <= req_be;
      lat_wdata <= req_wdata;
    end
  end

  assign in_row      = state_q inside {S_RAS, S_RASW};
  assign in_cas      = state_q inside {S_CAS1, S_CASW, S_CAS2};
  assign in_col      = in_cas || (state_q == S_COL);
  assign strobe_hold = state_q inside {S_RCAS, S_RRAS, S_RHOLD, S_SCAS, S_SHOLD, S_SEXIT};
  assign ras_both    = state_q inside {S_RRAS, S_RHOLD, S_SHOLD};

  always_comb begin
    dram_ras_n = ~b_open;
    if (ras_both) dram_ras_n = '0;
    if (strobe_hold)  dram_cas_n = '0;
    else if (in_cas)  dram_cas_n = cfg_dual_we[cur_bank] ? '0 : ~lat_be;
    else              dram_cas_n = '1;
    if (in_col && lat_we) dram_we_n = cfg_dual_we[cur_bank] ? ~lat_be : '0;
    else                  dram_we_n = '1;
    if (in_row)      dram_addr = b_row[cur_bank];
    else if (in_col) dram_addr = lat_col;
    else             dram_addr = '0;
  end

  assign dram_dq_out = lat_wdata;
  assign dram_dq_oe  = in_col && lat_we;
  assign rsp_valid   = (state_q == S_CAS2);
  assign rsp_rdata   = dram_dq_in;

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {S_RRAS, S_SHOLD}) && $fell(dram_ras_n[0])) |-> ($past(dram_cas_n) == '0)); // R9
  AST_PAGES_SHUT_FOR_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RCAS) |-> (dram_ras_n == '1)); // R9
  AST_PEND_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !fire); // R9
  AST_SELF_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SHOLD) |-> (dram_ras_n == '0 && dram_cas_n == '0)); // R10
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2

endmodule

// File: tb/dramc_two_bank_bench.sv
`timescale 1ns/1ps
module dramc_two_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [0:0]  req_bank = '0;
  logic [23:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [3:0]  cfg_colw = 4'b1100;
  logic [1:0]  cfg_dual_we = 2'b10;
  logic [1:0]  cfg_wait = 2'b00;
  logic [1:0]  cfg_page = 2'b00;
  logic [5:0]  cfg_ref_interval = '0;
  logic        selfref_req = 1'b0;
  logic [1:0]  dram_ras_n, dram_cas_n, dram_we_n;
  logic [11:0] dram_addr;
  logic [15:0] dram_dq_out;
  logic        dram_dq_oe;
  logic [15:0] dram_dq_in = 16'h5A3C;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit mopen [2];
  int mrow [2];

  always #4 clk = ~clk;

  dramc_two_bank u_dramc_two_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_colw(cfg_colw), .cfg_dual_we(cfg_dual_we), .cfg_wait(cfg_wait),
    .cfg_page(cfg_page), .cfg_ref_interval(cfg_ref_interval),
    .selfref_req(selfref_req), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cwidth(input int code);
    case (code)
      0: return 8;
      1: return 9;
      2: return 10;
      default: return 12;
    endcase
  endfunction

  task automatic do_access(input int b, input int addr, input bit we,
                           input logic [1:0] be, input logic [15:0] wd);
    int w, row, col, wt, lat, rdy;
    bit pg, hit, miss;
    string tag;
    logic [1:0] exp_cas, exp_we;
    w    = cwidth(int'(cfg_colw[2*b +: 2]));
    row  = (addr >> w) & 12'hFFF;
    col  = addr & ((1 << w) - 1);
    wt   = int'(cfg_wait[b]);
    pg   = cfg_page[b];
    hit  = mopen[b] && (mrow[b] == row) && pg;
    miss = mopen[b] && !hit;
    lat  = hit ? 2 + wt : (miss ? 1 : 0) + 4 + 2*wt;
    rdy  = pg ? lat + 1 : lat + 2;
    tag  = hit ? "R3 hit" : miss ? "R4 miss" : (wt != 0) ? "R5 wait" : "R2 closed";
    exp_cas = cfg_dual_we[b] ? 2'b00 : ~be;
    exp_we  = we ? (cfg_dual_we[b] ? ~be : 2'b00) : 2'b11;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 1'(b); req_addr = 24'(addr);
    req_we = we; req_be = be; req_wdata = wd;
    chk("R11 ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= rdy; n++) begin
      chk({tag, " rsp timing"}, rsp_valid, (n == lat));
      if (n == 1 && !hit && !miss) chk("R6 row on address", dram_addr, row);
      if (n == lat) begin
        chk("R6 column on address", dram_addr, col);
        chk("R7 cas pattern", dram_cas_n, exp_cas);
        chk("R7 we pattern", dram_we_n, exp_we);
        if (we) chk("R7 write data out", {dram_dq_oe, dram_dq_out}, {1'b1, wd});
        else    chk("R2 read data", rsp_rdata, 16'h5A3C);
      end
      if (n == rdy) chk({tag, " ready back"}, req_ready, 1);
      if (n < rdy) @(negedge clk);
    end
    mopen[b] = pg;
    mrow[b]  = row;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t1, t2, cyc, starts;
    bit found;
    logic [1:0] prev_ras, prev_cas;
    mopen[0] = 0; mopen[1] = 0; mrow[0] = 0; mrow[1] = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset strobes", {dram_ras_n, dram_cas_n, dram_we_n}, 6'b111111);
    chk("R2 reset ready/rsp", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;

    // closed-page accesses, both strobe arrangements, both column widths
    do_access(0, 24'h012345, 0, 2'b11, 16'h0);        // R2
    do_access(0, 24'h012345, 1, 2'b10, 16'hBEEF);     // R7 dual CAS
    do_access(1, 24'hABC123, 1, 2'b01, 16'h1234);     // R7 dual WE, R6 12-bit
    do_access(1, 24'hABC123, 0, 2'b11, 16'h0);        // R7 read dual WE
    cfg_wait = 2'b01;
    do_access(0, 24'h00F0AA, 0, 2'b11, 16'h0);        // R5
    cfg_wait = 2'b00;

    // page mode
    cfg_page = 2'b11;
    do_access(0, 24'h012345, 0, 2'b11, 16'h0);        // opens row
    do_access(0, 24'h012377, 0, 2'b11, 16'h0);        // R3 hit
    do_access(1, 24'h555010, 1, 2'b11, 16'h7777);     // other bank
    chk("R1 both rows held open", dram_ras_n, 2'b00);
    do_access(0, 24'h012301, 0, 2'b11, 16'h0);        // R1 bank0 still hits
    do_access(0, 24'h020001, 0, 2'b11, 16'h0);        // R4 miss

    // refresh with pages open
    cfg_ref_interval = 6'd2;
    prev_ras = dram_ras_n;
    found = 0;
    for (int i = 0; i < 40 && !found; i++) begin
      @(negedge clk);
      if (prev_ras[0] == 1'b0 && dram_ras_n[0] == 1'b1) found = 1;
      prev_ras = dram_ras_n;
    end
    chk("R9 page closed for refresh", found, 1);
    chk("R9 precharge cycle strobes", {dram_ras_n, dram_cas_n}, 4'b1111);
    @(negedge clk);
    chk("R9 CAS before RAS", {dram_ras_n, dram_cas_n}, 4'b1100);
    @(negedge clk);
    chk("R9 RAS follows CAS", {dram_ras_n, dram_cas_n}, 4'b0000);
    mopen[0] = 0; mopen[1] = 0;
    prev_cas = dram_cas_n;
    t1 = -1; t2 = -1; cyc = 0;
    for (int i = 0; i < 60 && t2 < 0; i++) begin
      @(negedge clk);
      cyc++;
      if (prev_cas == 2'b11 && dram_cas_n == 2'b00 && dram_ras_n == 2'b11) begin
        if (t1 < 0) t1 = cyc; else t2 = cyc;
      end
      prev_cas = dram_cas_n;
    end
    chk("R8 refresh spacing", t2 - t1, 8);
    repeat (4) @(negedge clk);
    cfg_ref_interval = 6'd0;
    starts = 0;
    prev_cas = dram_cas_n;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (prev_cas == 2'b11 && dram_cas_n == 2'b00) starts++;
      prev_cas = dram_cas_n;
    end
    chk("R8 interval zero gives no refresh", starts, 0);
    do_access(0, 24'h020001, 0, 2'b11, 16'h0);        // R9 page was closed

    // self-refresh with a parked request
    @(negedge clk);
    selfref_req = 1'b1;
    req_valid = 1'b1; req_bank = 1'b1; req_addr = 24'h333444; req_we = 1'b0; req_be = 2'b11;
    @(negedge clk);
    chk("R10 pages closed on entry", {dram_ras_n, dram_cas_n}, 4'b1111);
    @(negedge clk);
    chk("R10 CAS low first", {dram_ras_n, dram_cas_n}, 4'b1100);
    @(negedge clk);
    chk("R10 both low", {dram_ras_n, dram_cas_n}, 4'b0000);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R11 no take in self-refresh", {req_ready, rsp_valid}, 2'b00);
      chk("R10 strobes held", {dram_ras_n, dram_cas_n}, 4'b0000);
    end
    selfref_req = 1'b0;
    @(negedge clk);
    chk("R10 RAS rises before CAS", {dram_ras_n, dram_cas_n, req_ready}, 5'b11000);
    @(negedge clk);
    chk("R11 held request now ready", {req_ready, dram_cas_n}, 3'b111);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= 4; n++) begin
      chk("R11 held request answered", rsp_valid, (n == 4));
      if (n < 4) @(negedge clk);
    end
    @(negedge clk);
    mopen[0] = 0; mopen[1] = 1; mrow[1] = 12'h333;
    do_access(0, 24'h020001, 0, 2'b11, 16'h0);        // R10 pages closed

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule